// File: doc/BRIEF.md
# Reset Source Qualifier and Cause Recorder

This block sits between the reset request sources of a chip and its reset generator. Each source delivers a single-cycle request pulse. The block checks every pulse against its enable. It merges the qualified pulses into one reset request, and it stretches that request so the reset generator always sees a pulse of a guaranteed minimum width.

The sources are:
- power-on and the reset pin;
- the battery and core brown-out detectors;
- the processor's system-reset request and the watchdog;
- a software request;
- three deep-power-down wake sources: the wake pin, the real-time clock and the OS event timer.

The block also keeps a retained status word, which software reads to learn why the chip last reset. This word holds one flag per cause, plus a 4-bit boot fatal-error counter. Software clears flags by writing ones to them. Only a power-on or brown-out event wipes the boot counter; the other resets leave it untouched.

The brown-out enables are hardened. Each detector has two 2-bit enable copies, and the detector is disabled only when both copies hold the pattern 0b10. A single upset bit therefore cannot silence brown-out protection. All ports are plain control and status pins, with no handshake. Requests are pulses that cannot be back-pressured, and the status outputs are levels.

Top module: `reset_cause_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `rst_req` is 0, `cause_flags` is 0 and `boot_err_cnt` is 0.
- R2: A pulse on `req_por`, `req_pin`, `req_sysrst` or `req_wdog` always qualifies; no enable gates these four sources.
- R3: The battery brown-out source is disabled only when `bodbat_en_a` and `bodbat_en_b` both equal 2'b10, and the core source follows the same rule with `bodcore_en_a`/`bodcore_en_b`. Every other code combination enables the source. Both sources share cause flag bit 2.
- R4: `req_soft` qualifies only while `soft_rst_en` is 1.
- R5: The three wake sources qualify only while `wake_rst_en` is 1.
- R6: After a cycle with at least one qualified request, `cause_flags` holds exactly the set of causes qualified in that cycle. The bit positions are: 0 power-on, 1 pin, 2 brown-out, 3 system reset, 4 watchdog, 5 software, 6 wake pin, 7 RTC wake, 8 OS-timer wake. If several causes qualify in the same cycle, all of their bits are set.
- R7: In cycles with no qualified request and no clear strobe, `cause_flags` holds its value. `boot_err_cnt` is cleared only by a qualified power-on or brown-out request; other qualified resets leave it unchanged.
- R8: Each cycle with `boot_err_inc` high increments `boot_err_cnt`, which saturates at 15. A qualified power-on or brown-out request in the same cycle takes precedence and clears the counter instead.
- R9: A cycle with `clr_stb` high clears every `cause_flags` bit that is set in `clr_mask` (write-one-to-clear). If a qualified request arrives in the same cycle, the new cause set wins and the clear is dropped.
- R10: `rst_req` rises in the cycle after a qualified request and stays high for exactly STRETCH_CYC (default 4) cycles after the last qualified request.
- R11: A request that does not qualify changes neither `rst_req` nor `cause_flags` nor `boot_err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the retained state |
| req_por | input | 1 | Power-on request pulse |
| req_pin | input | 1 | Reset pin request pulse |
| req_bodbat | input | 1 | Battery brown-out request pulse |
| req_bodcore | input | 1 | Core brown-out request pulse |
| req_sysrst | input | 1 | Processor system-reset request pulse |
| req_wdog | input | 1 | Watchdog request pulse |
| req_soft | input | 1 | Software reset request pulse |
| req_wk_pin | input | 1 | Deep-power-down wake pin pulse |
| req_wk_rtc | input | 1 | Deep-power-down RTC wake pulse |
| req_wk_ostmr | input | 1 | Deep-power-down OS-timer wake pulse |
| soft_rst_en | input | 1 | Enables the software source |
| wake_rst_en | input | 1 | Enables the three wake sources |
| bodbat_en_a | input | 2 | Battery brown-out enable, copy A (2'b10 = off) |
| bodbat_en_b | input | 2 | Battery brown-out enable, copy B (2'b10 = off) |
| bodcore_en_a | input | 2 | Core brown-out enable, copy A (2'b10 = off) |
| bodcore_en_b | input | 2 | Core brown-out enable, copy B (2'b10 = off) |
| clr_stb | input | 1 | Write strobe for clearing cause flags |
| clr_mask | input | 9 | Ones select the cause flags to clear |
| boot_err_inc | input | 1 | Increments the boot fatal-error counter |
| rst_req | output | 1 | Stretched combined reset request |
| cause_flags | output | 9 | Sticky reset cause flags |
| boot_err_cnt | output | 4 | Saturating boot fatal-error counter |

## Verification
The assertions check several properties on every cycle:
- a qualified request is followed by `rst_req` and by a cause word equal to the qualified set;
- once `rst_req` rises it does not drop in the next cycle;
- idle cycles leave the flags alone;
- a brown-out request with a non-disabling enable code always qualifies;
- the counter sticks at 15.

Some behaviours only the bench's scenarios can show, and it covers each of them:
- the exact stretch width;
- priority of a request over a clear in the same cycle;
- retention of the counter across pin and watchdog resets;
- the full cross of all 1024 enable-code combinations against every source.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  localparam int unsigned NUM_SRC   = 10;
  localparam int unsigned NUM_CAUSE = 9;
  localparam int unsigned BOOT_W    = 4;

  // Cause flag positions (software decodes these)
  localparam int unsigned C_POR   = 0;
  localparam int unsigned C_PIN   = 1;
  localparam int unsigned C_BOD   = 2;
  localparam int unsigned C_SYS   = 3;
  localparam int unsigned C_WDOG  = 4;
  localparam int unsigned C_SOFT  = 5;
  localparam int unsigned C_WKPIN = 6;
  localparam int unsigned C_WKRTC = 7;
  localparam int unsigned C_WKOS  = 8;

  localparam logic [1:0] BOD_OFF_CODE = 2'b10;

  typedef logic [NUM_CAUSE-1:0] cause_vec_t;

  typedef struct packed {
    logic       soft_en;
    logic       wake_en;
    logic [1:0] bat_a;
    logic [1:0] bat_b;
    logic [1:0] core_a;
    logic [1:0] core_b;
  } rcu_cfg_t;

  // A brown-out source is off only if both redundant copies say so
  function automatic logic bod_active(input logic [1:0] a, input logic [1:0] b);
    return !((a == BOD_OFF_CODE) && (b == BOD_OFF_CODE));
  endfunction

endpackage

// File: rtl/rcu_src_gate.sv
module rcu_src_gate
  import rcu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   req,
  input  rcu_cfg_t             cfg,
  output cause_vec_t           hit,
  output logic                 hard_hit
);
  // req order: 0 por,1 pin,2 bodbat,3 bodcore,4 sys,5 wdog,6 soft,7 wkpin,8 wkrtc,9 wkos
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_ok;

  always_comb begin
    src_en    = '1;
    src_en[2] = bod_active(cfg.bat_a, cfg.bat_b);
    src_en[3] = bod_active(cfg.core_a, cfg.core_b);
    src_en[6] = cfg.soft_en;
    src_en[7] = cfg.wake_en;
    src_en[8] = cfg.wake_en;
    src_en[9] = cfg.wake_en;
  end

  assign src_ok = req & src_en;

  // Fold the two brown-out sources into one cause bit; the rest map one-to-one
  always_comb begin
    hit         = '0;
    hit[C_POR]  = src_ok[0];
    hit[C_PIN]  = src_ok[1];
    hit[C_BOD]  = src_ok[2] | src_ok[3];
    hit[C_SYS]  = src_ok[4];
    hit[C_WDOG] = src_ok[5];
    hit[C_SOFT] = src_ok[6];
    hit[C_WKPIN]= src_ok[7];
    hit[C_WKRTC]= src_ok[8];
    hit[C_WKOS] = src_ok[9];
  end

  assign hard_hit = hit[C_POR] | hit[C_BOD];

  AST_BODBAT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req[2] && cfg.bat_a != BOD_OFF_CODE) |-> hit[C_BOD]); // R3
  AST_BODCORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req[3] && cfg.core_b != BOD_OFF_CODE) |-> hit[C_BOD]); // R3

endmodule

// File: rtl/rcu_cause_reg.sv
module rcu_cause_reg
  import rcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cause_vec_t         hit,
  input  logic               hard_hit,
  input  logic               clr_stb,
  input  cause_vec_t         clr_mask,
  input  logic               cnt_inc,
  output cause_vec_t         flags,
  output logic [BOOT_W-1:0]  cnt
);
  localparam logic [BOOT_W-1:0] CNT_MAX = '1;

  logic any_hit;
  assign any_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (any_hit) begin
      flags <= hit;
    end else if (clr_stb) begin
      flags <= flags & ~clr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hard_hit) begin
      cnt <= '0;
    end else if (cnt_inc && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FLAGS_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (flags == $past(hit))); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && !clr_stb) |=> $stable(flags)); // R7
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && hit == '0) |=> ((flags & $past(clr_mask)) == '0)); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !hard_hit) |=> (cnt == CNT_MAX)); // R8
  AST_CNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hard_hit && !cnt_inc) |=> $stable(cnt)); // R7

endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (trig) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign pulse = (remain != '0);

  initial begin
    AST_STRETCH_PARAM: assert (STRETCH_CYC >= 2); // R10
  end

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse); // R10
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |=> pulse); // R10

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_por,
  input  logic        req_pin,
  input  logic        req_bodbat,
  input  logic        req_bodcore,
  input  logic        req_sysrst,
  input  logic        req_wdog,
  input  logic        req_soft,
  input  logic        req_wk_pin,
  input  logic        req_wk_rtc,
  input  logic        req_wk_ostmr,
  input  logic        soft_rst_en,
  input  logic        wake_rst_en,
  input  logic [1:0]  bodbat_en_a,
  input  logic [1:0]  bodbat_en_b,
  input  logic [1:0]  bodcore_en_a,
  input  logic [1:0]  bodcore_en_b,
  input  logic        clr_stb,
  input  logic [8:0]  clr_mask,
  input  logic        boot_err_inc,
  output logic        rst_req,
  output logic [8:0]  cause_flags,
  output logic [3:0]  boot_err_cnt
);
  logic [NUM_SRC-1:0] req_vec;
  rcu_cfg_t           cfg;
  cause_vec_t         hit;
  logic               hard_hit;

  assign req_vec = {req_wk_ostmr, req_wk_rtc, req_wk_pin, req_soft, req_wdog,
                    req_sysrst, req_bodcore, req_bodbat, req_pin, req_por};

  always_comb begin
    cfg.soft_en = soft_rst_en;
    cfg.wake_en = wake_rst_en;
    cfg.bat_a   = bodbat_en_a;
    cfg.bat_b   = bodbat_en_b;
    cfg.core_a  = bodcore_en_a;
    cfg.core_b  = bodcore_en_b;
  end

  rcu_src_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_vec),
    .cfg      (cfg),
    .hit      (hit),
    .hard_hit (hard_hit)
  );

  rcu_cause_reg u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .hard_hit (hard_hit),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .cnt_inc  (boot_err_inc),
    .flags    (cause_flags),
    .cnt      (boot_err_cnt)
  );

  rcu_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (|hit),
    .pulse (rst_req)
  );

  AST_POR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    req_por |=> (rst_req && cause_flags[C_POR] && boot_err_cnt == '0)); // R2
  AST_WDOG_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    req_wdog |=> (rst_req && cause_flags[C_WDOG])); // R2
  AST_SOFT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec == 10'b0001000000 && !soft_rst_en && !clr_stb) |=> $stable(cause_flags)); // R4
  AST_WAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_rst_en && req_vec[9:7] != 3'b000 && req_vec[6:0] == '0 && !clr_stb)
      |=> $stable(cause_flags)); // R5

endmodule

// File: tb/reset_cause_unit_test.sv
module reset_cause_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] req = '0;
  logic [9:0] cfgv = '0;
  logic       clr_stb = 1'b0;
  logic [8:0] clr_mask = '0;
  logic       boot_err_inc = 1'b0;
  logic       rst_req;
  logic [8:0] cause_flags;
  logic [3:0] boot_err_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  reset_cause_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_por(req[0]), .req_pin(req[1]), .req_bodbat(req[2]), .req_bodcore(req[3]),
    .req_sysrst(req[4]), .req_wdog(req[5]), .req_soft(req[6]),
    .req_wk_pin(req[7]), .req_wk_rtc(req[8]), .req_wk_ostmr(req[9]),
    .soft_rst_en(cfgv[0]), .wake_rst_en(cfgv[1]),
    .bodbat_en_a(cfgv[3:2]), .bodbat_en_b(cfgv[5:4]),
    .bodcore_en_a(cfgv[7:6]), .bodcore_en_b(cfgv[9:8]),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .boot_err_inc(boot_err_inc),
    .rst_req(rst_req), .cause_flags(cause_flags), .boot_err_cnt(boot_err_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit src_enabled(input int s, input logic [9:0] c);
    case (s)
      2: return !(c[3:2] == 2'b10 && c[5:4] == 2'b10);
      3: return !(c[7:6] == 2'b10 && c[9:8] == 2'b10);
      6: return c[0];
      7, 8, 9: return c[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic int flag_pos(input int s);
    if (s < 2) return s;
    if (s < 4) return 2;
    return s - 1;
  endfunction

  // one-cycle request pulse; returns after the capturing edge
  task automatic pulse(input logic [9:0] v);
    @(negedge clk) req = v;
    @(negedge clk) req = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [8:0] exp_flags;
    logic [3:0] exp_cnt;
    int hi;

    repeat (3) @(negedge clk);
    check(rst_req == 0 && cause_flags == 0 && boot_err_cnt == 0, "R1 in reset",
          {rst_req, cause_flags, boot_err_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_req == 0 && cause_flags == 0 && boot_err_cnt == 0, "R1 after release",
          {rst_req, cause_flags, boot_err_cnt}, 0);

    // Sweep: every enable code combination against every source
    exp_flags = '0;
    for (int c = 0; c < 1024; c++) begin
      cfgv = c[9:0];
      for (int s = 0; s < 10; s++) begin
        bit en;
        en = src_enabled(s, cfgv);
        pulse(10'(1 << s));
        if (en) exp_flags = 9'(1 << flag_pos(s));
        if (s == 2 || s == 3)
          check(cause_flags == exp_flags, "R3 bod gating", cause_flags, exp_flags);
        else if (s == 6)
          check(cause_flags == exp_flags, "R4 soft gating", cause_flags, exp_flags);
        else if (s >= 7)
          check(cause_flags == exp_flags, "R5 wake gating", cause_flags, exp_flags);
        else
          check(cause_flags == exp_flags, "R2 unconditional", cause_flags, exp_flags);
        check(rst_req == en, "R11 R10 rst_req start", rst_req, en);
        repeat (3) @(negedge clk);
        check(rst_req == en, "R10 still high at cycle 4", rst_req, en);
        @(negedge clk);
        check(rst_req == 0, "R10 low after stretch", rst_req, 0);
      end
    end

    // Counter saturation and retention
    cfgv = 10'b0000000011;
    pulse(10'b0000000001); // POR clears counter
    @(negedge clk) boot_err_inc = 1'b1;
    repeat (20) @(negedge clk);
    boot_err_inc = 1'b0;
    check(boot_err_cnt == 15, "R8 saturates", boot_err_cnt, 15);
    pulse(10'b0000000010);
    check(boot_err_cnt == 15, "R7 pin keeps counter", boot_err_cnt, 15);
    check(cause_flags == 9'h002, "R6 pin flag only", cause_flags, 9'h002);
    pulse(10'b0000100000);
    check(boot_err_cnt == 15, "R7 wdog keeps counter", boot_err_cnt, 15);
    pulse(10'b0001000000);
    check(boot_err_cnt == 15, "R7 soft keeps counter", boot_err_cnt, 15);
    pulse(10'b0000001000);
    check(boot_err_cnt == 0, "R7 core brown-out clears counter", boot_err_cnt, 0);
    check(cause_flags == 9'h004, "R6 bod flag", cause_flags, 9'h004);
    @(negedge clk) boot_err_inc = 1'b1;
    repeat (3) @(negedge clk);
    boot_err_inc = 1'b0;
    check(boot_err_cnt == 3, "R8 counts three", boot_err_cnt, 3);
    // increment and power-on together: power-on wins
    @(negedge clk) begin req = 10'b0000000001; boot_err_inc = 1'b1; end
    @(negedge clk) begin req = '0; boot_err_inc = 1'b0; end
    check(boot_err_cnt == 0, "R8 por beats increment", boot_err_cnt, 0);
    // disabled brown-out leaves counter alone
    cfgv = 10'b1010101000;
    @(negedge clk) boot_err_inc = 1'b1;
    @(negedge clk) boot_err_inc = 1'b0;
    pulse(10'b0000001100);
    check(boot_err_cnt == 1, "R11 disabled bod keeps counter", boot_err_cnt, 1);
    check(cause_flags == 9'h001, "R11 disabled bod keeps flags", cause_flags, 9'h001);
    cfgv = 10'b0000000011;

    // Simultaneous causes and write-one-to-clear
    repeat (6) @(negedge clk);
    pulse(10'b0000110000);
    check(cause_flags == 9'h018, "R6 two causes same cycle", cause_flags, 9'h018);
    repeat (6) @(negedge clk);
    check(cause_flags == 9'h018, "R7 flags sticky", cause_flags, 9'h018);
    @(negedge clk) begin clr_stb = 1'b1; clr_mask = 9'h008; end
    @(negedge clk) begin clr_stb = 1'b0; clr_mask = '0; end
    check(cause_flags == 9'h010, "R9 partial clear", cause_flags, 9'h010);
    @(negedge clk) begin clr_stb = 1'b1; clr_mask = 9'h1FF; req = 10'b0000000010; end
    @(negedge clk) begin clr_stb = 1'b0; clr_mask = '0; req = '0; end
    check(cause_flags == 9'h002, "R9 request beats clear", cause_flags, 9'h002);
    @(negedge clk) begin clr_stb = 1'b1; clr_mask = 9'h1FF; end
    @(negedge clk) begin clr_stb = 1'b0; clr_mask = '0; end
    check(cause_flags == 9'h000, "R9 full clear", cause_flags, 0);
    pulse(10'b1110000000);
    check(cause_flags == 9'h1C0, "R5 R6 three wake causes", cause_flags, 9'h1C0);

    // Retrigger stretches from the last request
    repeat (6) @(negedge clk);
    pulse(10'b0000000010);
    @(negedge clk) req = 10'b0000100000;
    @(negedge clk) req = '0;
    hi = 0;
    while (rst_req && hi < 20) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 4, "R10 retrigger width", hi, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule